// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits in the fetch stage of a simple pipelined processor and guesses, in the same cycle, where fetch goes after the current program counter. It keeps a small direct-mapped table. Each slot of the table holds a valid flag, an address tag, the last known branch destination and a single bit recording whether that branch was taken the last time it ran. When the fetch address hits a slot, the block repeats the recorded outcome and, if that outcome was taken, sends fetch to the stored destination.

When the table has no entry for the fetch address, the block falls back to a static guess. This guess uses an optional early target hint supplied alongside the fetch address. A hinted target below the fetch address, which is a backward branch, is guessed taken. Every other miss is guessed not taken and falls through to the next sequential word.

Later in the pipeline, each resolved branch arrives on the update port together with the prediction that was made for it. The block writes or replaces the slot for that branch. In the same cycle, if the prediction was wrong, it raises a flush request and supplies the corrected fetch address.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) invalidates every slot, so every lookup in the cycle after reset reports pred_hit = 0.
- R2: A lookup hits when the slot chosen by fetch_pc[5:2] is valid and its tag equals fetch_pc[31:6]. On a hit, pred_taken equals the stored history bit, and a taken hit drives pred_next_pc to the stored destination.
- R3: Whenever pred_taken is 0, pred_next_pc equals fetch_pc + 4. This includes a hit whose history bit is 0.
- R4: On a miss with hint_valid = 1 and hint_target < fetch_pc, the prediction is taken and pred_next_pc equals hint_target.
- R5: On a miss with no hint, or with a hint at or above fetch_pc, the prediction is not taken.
- R6: Each cycle with upd_valid = 1 writes the slot for upd_pc with valid set, its tag, upd_target and history bit upd_taken. A lookup of that address from the next cycle on sees the new contents.
- R7: A lookup and an update to the same slot in one cycle return the slot's contents from before the write.
- R8: flush_req is 1 in an update cycle where upd_taken differs from upd_pred_taken. flush_pc is then upd_target if the branch was taken, and upd_pc + 4 if it was not.
- R9: flush_req is 1 in an update cycle where the branch was taken, was predicted taken, and upd_target differs from upd_pred_target. flush_pc is then upd_target.
- R10: flush_req is 0 when upd_valid is 0, and it is also 0 when direction agrees and, for a taken branch, the target agrees. The target is not compared for a branch that was not taken.
- R11: Two addresses that share fetch_pc[5:2] but differ in the tag evict each other. The address that does not own the slot misses.
- R12: A loop-exit branch that is taken only on the final pass is mispredicted exactly twice on a repeated run of the loop: on the first pass and on the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| hint_valid | input | 1 | An early target is known for fetch_pc |
| hint_target | input | 32 | Early target used only on a table miss |
| pred_hit | output | 1 | Table holds an entry for fetch_pc |
| pred_taken | output | 1 | Predicted direction |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | 32 | Actual destination |
| upd_pred_taken | input | 1 | Direction that was predicted for it |
| upd_pred_target | input | 32 | Next address that was predicted for it |
| flush_req | output | 1 | Misprediction: discard younger instructions |
| flush_pc | output | 32 | Corrected fetch address |

## Verification
The assertions check the following on every cycle. A not-taken guess always falls through to the next word. A miss follows the static backward/forward rule. The flush output obeys its agreement and disagreement conditions. An update is seen by a lookup of the same address one cycle later, and nothing hits just after reset. Only the bench scenarios can show these: the old contents returned on a same-cycle lookup and write, eviction between aliasing addresses, and the two mispredictions that a repeated loop run costs. Each of these depends on a history of several updates.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned OFS_W       = 2;

    typedef enum logic [1:0] {
        SRC_SEQ     = 2'd0,
        SRC_DYNAMIC = 2'd1,
        SRC_STATIC  = 2'd2
    } pred_src_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_target,
    output logic             rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  logic             wr_hist
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0]            hist;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][PC_W-1:0]  target;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tbl_d.valid[i]  = 1'b1;
                tbl_d.hist[i]   = wr_hist;
                tbl_d.tag[i]    = wr_tag;
                tbl_d.target[i] = wr_target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q.valid <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rd_valid  = tbl_q.valid[rd_idx];
        rd_hist   = tbl_q.hist[rd_idx];
        rd_tag    = tbl_q.tag[rd_idx];
        rd_target = tbl_q.target[rd_idx];
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned TAG_W = 26
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic             hint_valid,
    input  logic [PC_W-1:0]  hint_target,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_target,
    input  logic             ent_hist,
    output logic             hit,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output pred_src_e        src
);
    logic [PC_W-1:0] seq_pc;
    logic            backward;

    always_comb begin
        seq_pc   = fetch_pc + PC_W'(INSTR_BYTES);
        hit      = ent_valid && (ent_tag == fetch_tag);
        backward = hint_valid && (hint_target < fetch_pc);
        if (hit) begin
            src   = SRC_DYNAMIC;
            taken = ent_hist;
        end else if (backward) begin
            src   = SRC_STATIC;
            taken = 1'b1;
        end else begin
            src   = SRC_SEQ;
            taken = 1'b0;
        end
        case (src)
            SRC_DYNAMIC: next_pc = ent_hist ? ent_target : seq_pc;
            SRC_STATIC:  next_pc = hint_target;
            default:     next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict,
    output logic [PC_W-1:0] correct_pc
);
    logic dir_wrong;
    logic tgt_wrong;

    always_comb begin
        dir_wrong  = upd_taken != upd_pred_taken;
        tgt_wrong  = upd_taken && upd_pred_taken && (upd_target != upd_pred_target);
        mispredict = upd_valid && (dir_wrong || tgt_wrong);
        correct_pc = upd_taken ? upd_target : (upd_pc + PC_W'(INSTR_BYTES));
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            hint_valid,
    input  logic [PC_W-1:0] hint_target,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            flush_req,
    output logic [PC_W-1:0] flush_pc
);
    localparam int unsigned TAG_LSB = OFS_W + IDX_W;
    localparam int unsigned TAG_W   = PC_W - TAG_LSB;

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] fetch_tag, wr_tag;
    logic             ent_valid, ent_hist;
    logic [TAG_W-1:0] ent_tag;
    logic [PC_W-1:0]  ent_target;
    pred_src_e        pred_src;

    assign rd_idx    = fetch_pc[TAG_LSB-1:OFS_W];
    assign fetch_tag = fetch_pc[PC_W-1:TAG_LSB];
    assign wr_idx    = upd_pc[TAG_LSB-1:OFS_W];
    assign wr_tag    = upd_pc[PC_W-1:TAG_LSB];

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (rd_idx),
        .rd_valid  (ent_valid),
        .rd_tag    (ent_tag),
        .rd_target (ent_target),
        .rd_hist   (ent_hist),
        .wr_en     (upd_valid),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (upd_target),
        .wr_hist   (upd_taken)
    );

    btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
        .fetch_pc    (fetch_pc),
        .fetch_tag   (fetch_tag),
        .hint_valid  (hint_valid),
        .hint_target (hint_target),
        .ent_valid   (ent_valid),
        .ent_tag     (ent_tag),
        .ent_target  (ent_target),
        .ent_hist    (ent_hist),
        .hit         (pred_hit),
        .taken       (pred_taken),
        .next_pc     (pred_next_pc),
        .src         (pred_src)
    );

    btb_resolve #(.PC_W(PC_W)) u_resolve (
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_target      (upd_target),
        .upd_pred_taken  (upd_pred_taken),
        .upd_pred_target (upd_pred_target),
        .mispredict      (flush_req),
        .correct_pc      (flush_pc)
    );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            hint_valid,
    input logic [PC_W-1:0] hint_target,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            upd_pred_taken,
    input logic [PC_W-1:0] upd_pred_target,
    input logic            flush_req,
    input logic [PC_W-1:0] flush_pc
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !pred_hit);

    // R3
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4));

    // R4
    static_backward_chk: assert property (@(posedge clk) disable iff (rst)
        (!pred_hit && hint_valid && hint_target < fetch_pc)
            |-> (pred_taken && pred_next_pc == hint_target));

    // R5
    static_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (!pred_hit && !(hint_valid && hint_target < fetch_pc)) |-> !pred_taken);

    // R6
    update_visible_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> ((fetch_pc == $past(upd_pc))
            -> (pred_hit && pred_taken == $past(upd_taken))));

    // R8
    dir_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken != upd_pred_taken)
            |-> (flush_req && flush_pc == (upd_taken ? upd_target : upd_pc + PC_W'(4))));

    // R9
    tgt_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && upd_pred_taken && upd_target != upd_pred_target)
            |-> (flush_req && flush_pc == upd_target));

    // R10
    no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid || (upd_taken == upd_pred_taken
            && (!upd_taken || upd_target == upd_pred_target))) |-> !flush_req);
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_btb_checker (
    .clk             (clk),
    .rst             (rst),
    .fetch_pc        (fetch_pc),
    .hint_valid      (hint_valid),
    .hint_target     (hint_target),
    .pred_hit        (pred_hit),
    .pred_taken      (pred_taken),
    .pred_next_pc    (pred_next_pc),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_taken       (upd_taken),
    .upd_target      (upd_target),
    .upd_pred_taken  (upd_pred_taken),
    .upd_pred_target (upd_pred_target),
    .flush_req       (flush_req),
    .flush_pc        (flush_pc)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        hint_valid = 1'b0;
    logic [31:0] hint_target = '0;
    logic        pred_hit, pred_taken, flush_req;
    logic [31:0] pred_next_pc, flush_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_pred_taken = 1'b0;
    logic [31:0] upd_pred_target = '0;

    always #4 clk = ~clk;

    btb_predictor dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .hint_valid(hint_valid),
        .hint_target(hint_target), .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_next_pc(pred_next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
        .flush_req(flush_req), .flush_pc(flush_pc)
    );

    typedef struct {
        string       req;
        logic        hit;
        logic        taken;
        logic [31:0] next;
        logic        flush;
        logic [31:0] fpc;
    } exp_t;

    exp_t  sb_q[$];
    event  sample_ev;
    int    n_tests = 0;
    int    n_fail  = 0;
    int    loop_flushes = 0;
    bit    done = 1'b0;

    // bench reference table, updated from the requirements
    bit          m_valid[16];
    logic [25:0] m_tag[16];
    logic [31:0] m_tgt[16];
    bit          m_hist[16];
    logic        last_taken;
    logic [31:0] last_next;

    task automatic step(input string req, input logic [31:0] fpc, input bit hv,
                        input logic [31:0] ht, input bit uv, input logic [31:0] upc,
                        input bit ut, input logic [31:0] utgt, input bit upt,
                        input logic [31:0] uptgt);
        exp_t e;
        int   ix;
        int   ux;
        @(negedge clk);
        fetch_pc = fpc; hint_valid = hv; hint_target = ht;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        upd_pred_taken = upt; upd_pred_target = uptgt;
        ix = int'(fpc[5:2]);
        e.req   = req;
        e.hit   = m_valid[ix] && (m_tag[ix] == fpc[31:6]);
        e.taken = e.hit ? m_hist[ix] : (hv && ht < fpc);
        e.next  = !e.taken ? fpc + 32'd4 : (e.hit ? m_tgt[ix] : ht);
        e.flush = uv && ((ut != upt) || (ut && upt && utgt != uptgt));
        e.fpc   = ut ? utgt : upc + 32'd4;
        last_taken = e.taken;
        last_next  = e.next;
        sb_q.push_back(e);
        #2 -> sample_ev;
        @(posedge clk);
        if (uv) begin
            ux = int'(upc[5:2]);
            m_valid[ux] = 1'b1; m_tag[ux] = upc[31:6];
            m_tgt[ux] = utgt; m_hist[ux] = ut;
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_tests++;
                if (pred_hit !== e.hit || pred_taken !== e.taken || pred_next_pc !== e.next
                    || flush_req !== e.flush || (e.flush && flush_pc !== e.fpc)) begin
                    n_fail++;
                    $display("FAIL %s: hit/taken/next/flush/fpc got %b/%b/%h/%b/%h exp %b/%b/%h/%b/%h",
                             e.req, pred_hit, pred_taken, pred_next_pc, flush_req, flush_pc,
                             e.hit, e.taken, e.next, e.flush, e.fpc);
                end
                if (e.req == "R12" && flush_req === 1'b1) loop_flushes++;
            end
        end
    end

    task automatic loop_run();
        bit          lt;
        logic [31:0] ln;
        for (int it = 1; it <= 10; it++) begin
            step("R12", 32'h300, 1'b1, 32'h340, 1'b0, '0, 1'b0, '0, 1'b0, '0);
            lt = last_taken; ln = last_next;
            step("R12", 32'h0, 1'b0, '0, 1'b1, 32'h300, (it == 10), 32'h340, lt, ln);
        end
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: nothing hits after reset; R5 no hint
        step("R1", 32'h100, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R4 backward hint on a miss
        step("R4", 32'h200, 1'b1, 32'h180, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R5 forward hint on a miss
        step("R5", 32'h200, 1'b1, 32'h280, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R7 + R8: update 0x140 taken, predicted not taken; lookup same slot sees old
        step("R7", 32'h140, 1'b0, '0, 1'b1, 32'h140, 1'b1, 32'h100, 1'b0, 32'h144);
        // R2 / R6: hit taken to stored target
        step("R2", 32'h140, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R9 target mismatch
        step("R9", 32'h0, 1'b0, '0, 1'b1, 32'h140, 1'b1, 32'h120, 1'b1, 32'h100);
        // R6 new target visible
        step("R6", 32'h140, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R10 correct taken prediction
        step("R10", 32'h0, 1'b0, '0, 1'b1, 32'h140, 1'b1, 32'h120, 1'b1, 32'h120);
        // R8 not-taken resolve of a predicted-taken branch: flush to pc+4
        step("R8", 32'h0, 1'b0, '0, 1'b1, 32'h140, 1'b0, 32'h120, 1'b1, 32'h120);
        // R10 not taken both ways, targets differ: no flush
        step("R10", 32'h0, 1'b0, '0, 1'b1, 32'h140, 1'b0, 32'h999, 1'b0, 32'h144);
        // R3 hit with history 0 falls through, even with a backward hint
        step("R3", 32'h140, 1'b1, 32'h40, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R11 aliasing slot, different tag
        step("R11", 32'h1140, 1'b0, '0, 1'b1, 32'h1140, 1'b1, 32'h2000, 1'b1, 32'h2000);
        step("R11", 32'h140, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        step("R11", 32'h1140, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R12 loop: first run, then repeated run
        loop_run();
        loop_flushes = 0;
        loop_run();
        @(negedge clk);
        upd_valid = 1'b0;
        #3;
        n_tests++;
        if (loop_flushes != 2) begin
            n_fail++;
            $display("FAIL R12: repeated loop mispredictions got %0d exp 2", loop_flushes);
        end
        // R1 again: reset mid-run clears learned entries
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
        step("R1", 32'h1140, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        step("R1", 32'h300, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule